// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block decides, at a fixed sample point ahead of each instruction fetch, whether a maskable interrupt request is taken. When it is, the block clears the interrupt-enable flag and runs acknowledge machine cycles that read an instruction from external interrupt logic. An acknowledge cycle has opcode-fetch timing. The block strobes an acknowledge line in place of the read strobe and drives the I/O-or-memory status bit high.

A first acknowledge cycle fetches the opcode. A small length decoder then says whether one or two more acknowledge cycles are needed to collect operand bytes, as with a three-byte call. The block only reports a non-maskable trap or a restart pin that wins over the maskable request; it does not service it. It also does not execute the fetched instruction. The surrounding core supplies the sample pulse and the program counter, and takes the captured bytes when the done pulse comes.

Top module: `intack_seq`

## Requirements
- R1: After reset, ie_o, ack_o, ale_o, done_o, trap_won_o and rst_won_o are 0, status_o is 3'b000, addr_o, opcode_o and operand_o are 0, and len_o reads 1.
- R2: ie_o goes to 1 in the cycle after ei_i is high and di_i is low. It goes to 0 in the cycle after di_i is high, and di_i wins when both are high. Nothing else sets it.
- R3: Requests are examined only in a cycle with sample_i high while no sequence is in progress. A sample pulse during a sequence has no effect.
- R4: At a sample point, trap_i wins regardless of ie_o. Next come the restart pins, which need ie_o=1, and among them the higher index wins. Last comes intr_i, which needs ie_o=1. A winning trap or restart pin gives a one-cycle pulse on trap_won_o, or a one-hot value on rst_won_o, in the next cycle. It starts no acknowledge cycle and leaves ie_o unchanged.
- R5: When intr_i is the only valid request, ie_o reads 0 in the cycle after the sample. Then one idle cycle passes, and T1 of the first acknowledge cycle falls two cycles after the sample cycle.
- R6: The first acknowledge cycle lasts six states (T1..T6). ale_o is high in T1, ack_o is high in T2 and T3, and opcode_o takes data_i at the end of T3.
- R7: status_o ({io_m, s1, s0}) is 3'b111 in every state of every acknowledge cycle, and 3'b000 at all other times.
- R8: In every acknowledge state, addr_o carries the pc_i value present at the sample point. At all other times it is 0.
- R9: The length decoder gives 3 bytes for 0xCD, 0xC3, 0x22, 0x2A, 0x32 and 0x3A, for 11xxx010, for 11xxx100 and for 00xx0001. It gives 2 bytes for 00xxx110, for 11xxx110, for 0xD3 and for 0xDB. Every other opcode, including the restart opcodes 11xxx111, gives 1 byte.
- R10: Each further byte takes a three-state acknowledge cycle (ALE in T1, ack_o in T2 and T3, capture at the end of T3). The second byte goes to operand_o[7:0] and the third to operand_o[15:8]. Unfetched bytes read 0, so 0xCD takes exactly two further cycles.
- R11: done_o pulses for one cycle, in the cycle after the last state of the last acknowledge cycle. opcode_o, operand_o and len_o then hold until the next accepted interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Marks the request sample point |
| intr_i | input | 1 | Maskable interrupt request |
| trap_i | input | 1 | Non-maskable trap request |
| rst_req_i | input | NUM_RST | Restart request pins, higher index has priority |
| ei_i | input | 1 | Enable-interrupts command |
| di_i | input | 1 | Disable-interrupts command |
| pc_i | input | ADDR_W | Current program counter |
| data_i | input | 8 | Data bus from the interrupt logic |
| ack_o | output | 1 | Acknowledge strobe, active high |
| ale_o | output | 1 | Address latch enable |
| status_o | output | 3 | {io_m, s1, s0} |
| addr_o | output | ADDR_W | Address bus |
| opcode_o | output | 8 | Captured first byte |
| operand_o | output | 16 | Captured operand bytes, high byte is the third |
| len_o | output | 2 | Decoded instruction length |
| done_o | output | 1 | Sequence complete pulse |
| trap_won_o | output | 1 | Trap beat the maskable request |
| rst_won_o | output | NUM_RST | One-hot restart pin that won |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
The hardest case to reach is a sample pulse that arrives while an acknowledge sequence is already running, because the core would normally not issue one. The bench raises sample_i together with trap_i in the middle of the first acknowledge cycle and checks that no trap win is reported. It also runs the full acknowledge sequence for all 256 opcodes, so every length class and every cycle boundary is reached. In addition it sweeps every restart-pin pattern, with and without the enable flag.

// File: rtl/intack_pkg.sv
package intack_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_RUN, ST_DONE} seq_st_e;

  function automatic logic [1:0] instr_len(input logic [BYTE_W-1:0] op);
    logic [1:0] n;
    casez (op)
      8'hCD, 8'hC3, 8'h22, 8'h2A, 8'h32, 8'h3A: n = 2'd3;
      8'b11???010, 8'b11???100:                 n = 2'd3;
      8'b00??0001:                              n = 2'd3;
      8'b00???110, 8'b11???110:                 n = 2'd2;
      8'hD3, 8'hDB:                             n = 2'd2;
      default:                                  n = 2'd1;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/intack_arb.sv
module intack_arb #(
  parameter int NUM_RST = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic               busy_i,
  input  logic               intr_i,
  input  logic               trap_i,
  input  logic [NUM_RST-1:0] rst_req_i,
  input  logic               ei_i,
  input  logic               di_i,
  output logic               take_o,
  output logic               trap_won_o,
  output logic [NUM_RST-1:0] rst_won_o,
  output logic               ie_o
);
  logic               ie_q;
  logic               trap_won_q;
  logic [NUM_RST-1:0] rst_won_q;
  logic [NUM_RST-1:0] rst_valid;
  logic [NUM_RST-1:0] rst_sel;
  logic               open_w;

  assign rst_valid = rst_req_i & {NUM_RST{ie_q}};
  assign open_w    = sample_i & ~busy_i;

  // highest index overwrites lower ones
  always_comb begin
    rst_sel = '0;
    for (int i = 0; i < NUM_RST; i++) begin
      if (rst_valid[i]) rst_sel = NUM_RST'(1) << i;
    end
  end

  assign take_o = open_w & ~trap_i & ~(|rst_valid) & intr_i & ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q       <= 1'b0;
      trap_won_q <= 1'b0;
      rst_won_q  <= '0;
    end else begin
      trap_won_q <= open_w & trap_i;
      rst_won_q  <= (open_w & ~trap_i) ? rst_sel : '0;
      if (di_i || take_o)  ie_q <= 1'b0;
      else if (ei_i)       ie_q <= 1'b1;
    end
  end

  assign trap_won_o = trap_won_q;
  assign rst_won_o  = rst_won_q;
  assign ie_o       = ie_q;
endmodule

// File: rtl/intack_fsm.sv
module intack_fsm
  import intack_pkg::*;
#(
  parameter int FIRST_T = 6,
  parameter int NEXT_T  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic [1:0] len_i,
  output logic       busy_o,
  output logic       seq_o,
  output logic       ale_o,
  output logic       ack_o,
  output logic       cap_o,
  output logic [1:0] bidx_o,
  output logic       done_o
);
  localparam int TW = $clog2(FIRST_T + 1);

  seq_st_e       st_q;
  logic [TW-1:0] t_q;
  logic [1:0]    b_q;
  logic          last_t;
  logic          more;

  assign last_t = (b_q == 2'd0) ? (t_q == TW'(FIRST_T)) : (t_q == TW'(NEXT_T));
  assign more   = ({1'b0, b_q} + 3'd1) < {1'b0, len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      t_q  <= '0;
      b_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take_i) st_q <= ST_GAP;
        ST_GAP: begin
          st_q <= ST_RUN;
          t_q  <= TW'(1);
          b_q  <= 2'd0;
        end
        ST_RUN: begin
          if (last_t) begin
            if (more) begin
              b_q <= b_q + 2'd1;
              t_q <= TW'(1);
            end else begin
              st_q <= ST_DONE;
              t_q  <= '0;
            end
          end else begin
            t_q <= t_q + TW'(1);
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign seq_o  = (st_q == ST_RUN);
  assign ale_o  = seq_o && (t_q == TW'(1));
  assign ack_o  = seq_o && ((t_q == TW'(2)) || (t_q == TW'(3)));
  assign cap_o  = seq_o && (t_q == TW'(3));
  assign bidx_o = b_q;
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/intack_capture.sv
module intack_capture
  import intack_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              cap_i,
  input  logic [1:0]        bidx_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [BYTE_W-1:0] opcode_o,
  output logic [2*BYTE_W-1:0] operand_o,
  output logic [1:0]        len_o
);
  logic [ADDR_W-1:0]   pc_q;
  logic [BYTE_W-1:0]   op_q;
  logic [2*BYTE_W-1:0] opd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      op_q  <= '0;
      opd_q <= '0;
    end else if (take_i) begin
      pc_q  <= pc_i;
      op_q  <= '0;
      opd_q <= '0;
    end else if (cap_i) begin
      unique case (bidx_i)
        2'd0:    op_q <= data_i;
        2'd1:    opd_q[BYTE_W-1:0] <= data_i;
        default: opd_q[2*BYTE_W-1:BYTE_W] <= data_i;
      endcase
    end
  end

  assign pc_o      = pc_q;
  assign opcode_o  = op_q;
  assign operand_o = opd_q;
  assign len_o     = instr_len(op_q);
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_RST = 3,
  parameter int FIRST_T = 6,
  parameter int NEXT_T  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic               intr_i,
  input  logic               trap_i,
  input  logic [NUM_RST-1:0] rst_req_i,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [7:0]         data_i,
  output logic               ack_o,
  output logic               ale_o,
  output logic [2:0]         status_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [7:0]         opcode_o,
  output logic [15:0]        operand_o,
  output logic [1:0]         len_o,
  output logic               done_o,
  output logic               trap_won_o,
  output logic [NUM_RST-1:0] rst_won_o,
  output logic               ie_o
);
  logic              take_w;
  logic              busy_w;
  logic              seq_w;
  logic              cap_w;
  logic [1:0]        bidx_w;
  logic [ADDR_W-1:0] pc_w;

  intack_arb #(.NUM_RST(NUM_RST)) u_arb (
    .clk_i, .rst_ni, .sample_i,
    .busy_i(busy_w), .intr_i, .trap_i, .rst_req_i, .ei_i, .di_i,
    .take_o(take_w), .trap_won_o, .rst_won_o, .ie_o
  );

  intack_fsm #(.FIRST_T(FIRST_T), .NEXT_T(NEXT_T)) u_fsm (
    .clk_i, .rst_ni, .take_i(take_w), .len_i(len_o),
    .busy_o(busy_w), .seq_o(seq_w), .ale_o, .ack_o,
    .cap_o(cap_w), .bidx_o(bidx_w), .done_o
  );

  intack_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i, .rst_ni, .take_i(take_w), .cap_i(cap_w), .bidx_i(bidx_w),
    .data_i, .pc_i, .pc_o(pc_w), .opcode_o, .operand_o, .len_o
  );

  // io_m, s1, s0 all high during acknowledge
  assign status_o = seq_w ? 3'b111 : 3'b000;
  assign addr_o   = seq_w ? pc_w : '0;
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int NUM_RST = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sample_i,
  input logic               intr_i,
  input logic               trap_i,
  input logic [NUM_RST-1:0] rst_req_i,
  input logic               ei_i,
  input logic               di_i,
  input logic               busy_i,
  input logic               ack_o,
  input logic               ale_o,
  input logic [2:0]         status_o,
  input logic               done_o,
  input logic               trap_won_o,
  input logic [NUM_RST-1:0] rst_won_o,
  input logic               ie_o
);
  a_r2_di_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !ie_o);
  a_r2_ei_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !di_i && !sample_i) |=> ie_o);
  a_r3_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && busy_i) |=> (!trap_won_o && rst_won_o == '0));
  a_r4_trap_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !busy_i && trap_i) |=> (trap_won_o && !busy_i));
  a_r4_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trap_won_o, rst_won_o}));
  a_r5_take_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !busy_i && intr_i && ie_o && !trap_i && rst_req_i == '0 && !ei_i)
      |=> (!ie_o && busy_i));
  a_r6_ale_then_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> ack_o);
  a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && ack_o));
  a_r7_status_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o || ack_o) |-> status_o == 3'b111);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && status_o == 3'b000);
endmodule

bind intack_seq intack_seq_chk #(.NUM_RST(NUM_RST)) u_chk (
  .clk_i, .rst_ni, .sample_i, .intr_i, .trap_i, .rst_req_i, .ei_i, .di_i,
  .busy_i(busy_w), .ack_o, .ale_o, .status_o, .done_o, .trap_won_o,
  .rst_won_o, .ie_o
);

// File: tb/intack_seq_bench.sv
module intack_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sample_i = 1'b0, intr_i = 1'b0, trap_i = 1'b0;
  logic [NR-1:0] rst_req_i = '0;
  logic          ei_i = 1'b0, di_i = 1'b0;
  logic [15:0]   pc_i = '0;
  logic [7:0]    data_i = '0;
  logic          ack_o, ale_o, done_o, trap_won_o, ie_o;
  logic [2:0]    status_o;
  logic [15:0]   addr_o, operand_o;
  logic [7:0]    opcode_o;
  logic [1:0]    len_o;
  logic [NR-1:0] rst_won_o;

  int n_run = 0;
  int n_fail = 0;

  intack_seq u_intack_seq (
    .clk_i, .rst_ni, .sample_i, .intr_i, .trap_i, .rst_req_i, .ei_i, .di_i,
    .pc_i, .data_i, .ack_o, .ale_o, .status_o, .addr_o, .opcode_o,
    .operand_o, .len_o, .done_o, .trap_won_o, .rst_won_o, .ie_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int len_ref(input logic [7:0] op);
    logic [1:0] hi = op[7:6];
    logic [2:0] lo = op[2:0];
    if (op == 8'hCD || op == 8'hC3 || op == 8'h22 || op == 8'h2A ||
        op == 8'h32 || op == 8'h3A) return 3;
    if (hi == 2'd3 && (lo == 3'd2 || lo == 3'd4)) return 3;
    if (hi == 2'd0 && op[3:0] == 4'd1) return 3;
    if (lo == 3'd6 && (hi == 2'd0 || hi == 2'd3)) return 2;
    if (op == 8'hD3 || op == 8'hDB) return 2;
    return 1;
  endfunction

  task automatic set_ie(input bit v);
    ei_i = v; di_i = !v;
    @(negedge clk_i);
    ei_i = 1'b0; di_i = 1'b0;
    chk(ie_o == v, "R2 ie after command", ie_o, v);
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      chk(!ack_o && !ale_o && status_o == 3'b000, req, {ack_o, ale_o, status_o}, 0);
    end
  endtask

  // full acknowledge run; inj raises a busy-time sample with trap in cycle 3
  task automatic run_intr(input logic [7:0] op, input logic [15:0] pcv, input bit inj);
    int len, done_c, t;
    bit e_ale, e_ack, e_seq, e_done;
    logic [7:0] b2, b3;
    logic [15:0] e_opd;
    b2 = op ^ 8'h5A;
    b3 = ~op;
    set_ie(1'b1);
    sample_i = 1'b1; intr_i = 1'b1; pc_i = pcv; data_i = op;
    @(negedge clk_i);
    sample_i = 1'b0; intr_i = 1'b0;
    len = len_ref(op);
    done_c = 8 + 3 * (len - 1);
    for (int c = 1; c <= done_c; c++) begin
      if (c == 1) chk(ie_o == 1'b0, "R5 ie cleared on take", ie_o, 0);
      if (c == 4 && inj) chk(!trap_won_o, "R3 busy sample ignored", trap_won_o, 0);
      e_seq = (c >= 2) && (c < done_c);
      e_done = (c == done_c);
      t = (c <= 7) ? c - 1 : ((c - 8) % 3) + 1;
      e_ale = e_seq && t == 1;
      e_ack = e_seq && (t == 2 || t == 3);
      chk(ale_o == e_ale, (c <= 7) ? "R6 ale first cycle" : "R10 ale operand cycle", ale_o, e_ale);
      chk(ack_o == e_ack, (c <= 7) ? "R6 ack first cycle" : "R10 ack operand cycle", ack_o, e_ack);
      chk(status_o == (e_seq ? 3'b111 : 3'b000), "R7 status", status_o, e_seq ? 7 : 0);
      chk(addr_o == (e_seq ? pcv : 16'h0), "R8 address", addr_o, e_seq ? pcv : 0);
      chk(done_o == e_done, "R11 done timing", done_o, e_done);
      if (c == 3 && inj) begin sample_i = 1'b1; trap_i = 1'b1; end
      if (c == 4 && inj) begin sample_i = 1'b0; trap_i = 1'b0; end
      if (c == 8) data_i = b2;
      if (c == 11) data_i = b3;
      if (c < done_c) @(negedge clk_i);
    end
    e_opd = (len == 3) ? {b3, b2} : (len == 2) ? {8'h00, b2} : 16'h0;
    chk(opcode_o == op, "R6 opcode captured", opcode_o, op);
    chk(len_o == 2'(len), "R9 length decode", len_o, len);
    chk(operand_o == e_opd, "R10 operand bytes", operand_o, e_opd);
    data_i = 8'hFF;
    @(negedge clk_i);
    chk(!done_o, "R11 done one cycle", done_o, 0);
    chk(opcode_o == op && operand_o == e_opd, "R11 hold after done", operand_o, e_opd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog R1..all act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(!ie_o && !ack_o && !ale_o && !done_o, "R1 reset strobes", {ie_o, ack_o, ale_o, done_o}, 0);
    chk(status_o == 3'b000 && addr_o == 16'h0, "R1 reset bus", addr_o, 0);
    chk(opcode_o == 8'h0 && operand_o == 16'h0 && len_o == 2'd1, "R1 reset capture", len_o, 1);
    chk(!trap_won_o && rst_won_o == '0, "R1 reset winners", rst_won_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 di wins over ei
    set_ie(1'b1);
    ei_i = 1'b1; di_i = 1'b1;
    @(negedge clk_i);
    ei_i = 1'b0; di_i = 1'b0;
    chk(!ie_o, "R2 di wins", ie_o, 0);

    // R3 no sample pulse, nothing happens
    set_ie(1'b1);
    intr_i = 1'b1; trap_i = 1'b1;
    quiet(4, "R3 no sample no cycle");
    intr_i = 1'b0; trap_i = 1'b0;
    chk(ie_o && !trap_won_o, "R3 no sample ie kept", ie_o, 1);

    // R5 intr masked when ie=0
    set_ie(1'b0);
    sample_i = 1'b1; intr_i = 1'b1;
    @(negedge clk_i);
    sample_i = 1'b0; intr_i = 1'b0;
    quiet(4, "R5 masked intr");

    // R4 trap with ie 0 and 1
    for (int v = 0; v < 2; v++) begin
      set_ie(v[0]);
      sample_i = 1'b1; trap_i = 1'b1; intr_i = 1'b1; rst_req_i = '1;
      @(negedge clk_i);
      sample_i = 1'b0; trap_i = 1'b0; intr_i = 1'b0; rst_req_i = '0;
      chk(trap_won_o && rst_won_o == '0, "R4 trap wins", {trap_won_o, rst_won_o}, 8);
      chk(ie_o == v[0], "R4 trap leaves ie", ie_o, v);
      @(negedge clk_i);
      chk(!trap_won_o, "R4 trap pulse one cycle", trap_won_o, 0);
      quiet(6, "R4 no ack after trap");
    end

    // R4 restart pin sweep, with and without enable
    for (int v = 0; v < 2; v++) begin
      for (int p = 1; p < (1 << NR); p++) begin
        logic [NR-1:0] e;
        e = '0;
        for (int i = 0; i < NR; i++) if (p[i] && v == 1) e = NR'(1) << i;
        set_ie(v[0]);
        sample_i = 1'b1; rst_req_i = NR'(p); intr_i = 1'b1;
        @(negedge clk_i);
        sample_i = 1'b0; rst_req_i = '0; intr_i = 1'b0;
        chk(rst_won_o == e, "R4 restart priority", rst_won_o, e);
        chk(ie_o == v[0] || (v == 0), "R4 restart leaves ie", ie_o, v);
        if (v == 1) quiet(6, "R4 no ack after restart");
        else @(negedge clk_i);
      end
    end

    // busy-time sample ignored, then exhaustive opcode sweep
    run_intr(8'hCD, 16'h1234, 1'b1);
    for (int op = 0; op < 256; op++) begin
      run_intr(8'(op), {8'(op), ~8'(op)}, 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule